// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block produces the horizontal sync, vertical sync and field pins for interlaced standard-definition video. It also produces the matching vertical and field flags that a downstream formatter places in its embedded timing codes. A free-running raster of pixel and line counters is clocked at the pixel rate. A standard select picks 525-line or 625-line framing. Every output edge is placed relative to those counters by configuration inputs.

The horizontal pulse is a window between two programmable pixel positions, and the window may wrap past the end of the line. Each vertical edge is a signed line offset from a per-field reference line: vertical-active begin, vertical-active end and field toggle. Each edge also has its own extra-line delay for the odd and even fields. The vertical sync pin changes on the same lines as the vertical flag, either at the start of the line or at mid-line. All configuration is captured once per frame, so a change made while a frame is running never produces a partial or glitched pulse.

Top module: `sync_timing_gen`

## Requirements
- R1: The pixel counter counts 0 to P-1 and the line counter counts 1 to L, where the select input chooses the framing: 0 gives L=525 with P=`PPL_525`, and 1 gives L=625 with P=`PPL_625`. The line counter advances when the pixel counter wraps.
- R2: A horizontal position p counts as inside the HS window when one of these holds: begin < end and begin <= p < end; or begin > end and (p >= begin or p < end). When begin equals end, the window is empty. The HS pin is active in the clock after the counters show a position inside the window.
- R3: Each of the three invert inputs flips exactly one pin: one inverts HS, one inverts VS, and one inverts the field pin. The V and F flags are never inverted.
- R4: For each vertical edge, the odd field's reference line is 1 and the even field's reference line is L/2+1 (263 or 313). The edge line is the reference plus the 5-bit offset when the direction bit is 0, or minus it when the bit is 1. One more line is added when that field's delay bit is 1. The result wraps modulo L into the range 1..L. V becomes 1 from pixel 0 of a begin line and 0 from pixel 0 of an end line, and it is visible one clock after the counters show pixel 0.
- R5: F becomes 0 at pixel 0 of the odd field's toggle line and 1 at pixel 0 of the even field's toggle line. It changes with the same one-clock lag as V. The field pin shows F, passed through its inversion.
- R6: VS changes on the same lines and in the same direction as V. With the mid-line input at 0, it changes with V at pixel 0. With the mid-line input at 1, it changes at pixel P/2 of that line, one clock after the counters show that pixel.
- R7: All configuration inputs, the standard select included, are sampled only in the clock where the counters show the last pixel of line L. A value applied partway through a frame has no effect until the next frame. Until the first such sample, the block uses these reset values: 525 lines, HS window 0..64, no inversion, line-start VS, begin = advance 5, end = delay 14, toggle = advance 3, and every delay bit 0.
- R8: During reset the counters read pixel 0, line 1, with HS=0, VS=1, field pin=0, V=1 and F=0.
- R9: When a begin line and an end line coincide, the end wins and V (and VS) go to 0. When the odd and even toggle lines coincide, the odd field wins and F goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_625_i | input | 1 | Framing select: 0 = 525 lines, 1 = 625 lines |
| hs_begin_i | input | 11 | Pixel position where HS becomes active |
| hs_end_i | input | 11 | Pixel position where HS becomes inactive |
| hs_inv_i | input | 1 | Invert HS pin |
| vs_inv_i | input | 1 | Invert VS pin |
| fld_inv_i | input | 1 | Invert field pin |
| vs_midline_i | input | 1 | 1 = VS changes at mid-line, 0 = at line start |
| vb_ofs_i | input | 5 | Vertical-active begin line offset |
| vb_adv_i | input | 1 | Begin direction: 0 delay, 1 advance |
| vb_dly_odd_i | input | 1 | Begin extra line, odd field |
| vb_dly_even_i | input | 1 | Begin extra line, even field |
| ve_ofs_i | input | 5 | Vertical-active end line offset |
| ve_adv_i | input | 1 | End direction: 0 delay, 1 advance |
| ve_dly_odd_i | input | 1 | End extra line, odd field |
| ve_dly_even_i | input | 1 | End extra line, even field |
| ft_ofs_i | input | 5 | Field toggle line offset |
| ft_adv_i | input | 1 | Toggle direction: 0 delay, 1 advance |
| ft_dly_odd_i | input | 1 | Toggle extra line, odd field |
| ft_dly_even_i | input | 1 | Toggle extra line, even field |
| hs_o | output | 1 | Horizontal sync pin |
| vs_o | output | 1 | Vertical sync pin |
| fld_o | output | 1 | Field pin |
| v_flag_o | output | 1 | Vertical flag for embedded timing codes |
| f_flag_o | output | 1 | Field flag for embedded timing codes |
| pix_cnt_o | output | 11 | Current pixel position |
| line_cnt_o | output | 10 | Current line number |

## Verification
The hardest case to reach is a configuration change that arrives in the middle of a frame. Such a change must stay invisible until the frame ends. It must then move the pins and the flags together, even when an advanced edge wraps backwards across the rollover into the previous frame's lines. The bench shortens the line length through the pixel-count parameters, so each scenario runs across whole frame boundaries. It changes the inputs at arbitrary clocks and compares every pin and flag on every clock against a model of the requirements. That model holds its own once-per-frame copy of the configuration. Scenarios with advanced offsets, per-field delays, wrapped HS windows, coincident edges and a switch of framing standard drive the block into the rollover and priority cases.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    localparam int HPOS_W = 11;
    localparam int OFS_W  = 5;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             adv;
        logic             dly_odd;
        logic             dly_even;
    } vedge_t;

    typedef struct packed {
        logic              std625;
        logic [HPOS_W-1:0] hs_beg;
        logic [HPOS_W-1:0] hs_end;
        logic              hs_inv;
        logic              vs_inv;
        logic              fld_inv;
        logic              vs_mid;
        vedge_t            vbeg;
        vedge_t            vend;
        vedge_t            ftog;
    } tim_cfg_t;

    localparam tim_cfg_t CFG_RESET = '{
        std625 : 1'b0,
        hs_beg : 11'd0,
        hs_end : 11'd64,
        hs_inv : 1'b0,
        vs_inv : 1'b0,
        fld_inv: 1'b0,
        vs_mid : 1'b0,
        vbeg   : '{ofs: 5'd5,  adv: 1'b1, dly_odd: 1'b0, dly_even: 1'b0},
        vend   : '{ofs: 5'd14, adv: 1'b0, dly_odd: 1'b0, dly_even: 1'b0},
        ftog   : '{ofs: 5'd3,  adv: 1'b1, dly_odd: 1'b0, dly_even: 1'b0}
    };

endpackage

// File: rtl/sync_raster_cnt.sv
module sync_raster_cnt #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  ppl_i,
    input  logic [LINE_W-1:0] lpf_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic [LINE_W-1:0] line_o,
    output logic              frame_end_o
);

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic line_end;

    always_comb begin
        cnt_d       = cnt_q;
        line_end    = (cnt_q.pix >= ppl_i - 1'b1);
        frame_end_o = line_end && (cnt_q.line >= lpf_i);
        if (line_end) begin
            cnt_d.pix = '0;
            if (cnt_q.line >= lpf_i) begin
                cnt_d.line = LINE_W'(1);
            end else begin
                cnt_d.line = cnt_q.line + 1'b1;
            end
        end else begin
            cnt_d.pix = cnt_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '{pix: '0, line: LINE_W'(1)};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pix_o  = cnt_q.pix;
    assign line_o = cnt_q.line;

    // R1: pixel position never reaches the line length
    assert_pix_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_o < ppl_i);

    // R1: line number stays in 1..L
    assert_line_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != '0) && (line_o <= lpf_i));

    // R1: line advances by one when a non-final line ends
    assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_end_o) |=> (line_o == $past(line_o) + 1'b1));

endmodule

// File: rtl/sync_cfg_hold.sv
module sync_cfg_hold
    import sync_gen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  tim_cfg_t cfg_i,
    output tim_cfg_t cfg_o
);

    tim_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d = cfg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sync_edge_line.sv
module sync_edge_line #(
    parameter int LINE_W = 10,
    parameter int OFS_W  = 5
) (
    input  logic [LINE_W-1:0] lpf_i,
    input  logic [LINE_W-1:0] ref_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              adv_i,
    input  logic              extra_i,
    output logic [LINE_W-1:0] line_o
);

    localparam int SUM_W = LINE_W + 2;

    logic [SUM_W-1:0] lpf_w, base, moved, once;

    always_comb begin
        lpf_w  = SUM_W'(lpf_i);
        base   = SUM_W'(ref_i) + lpf_w + SUM_W'(extra_i);
        moved  = adv_i ? (base - SUM_W'(ofs_i)) : (base + SUM_W'(ofs_i));
        once   = (moved > lpf_w) ? (moved - lpf_w) : moved;
        line_o = LINE_W'((once > lpf_w) ? (once - lpf_w) : once);
    end

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
    import sync_gen_pkg::*;
#(
    parameter int PPL_525   = 858,
    parameter int PPL_625   = 864,
    parameter int LINES_525 = 525,
    parameter int LINES_625 = 625
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        std_625_i,
    input  logic [10:0] hs_begin_i,
    input  logic [10:0] hs_end_i,
    input  logic        hs_inv_i,
    input  logic        vs_inv_i,
    input  logic        fld_inv_i,
    input  logic        vs_midline_i,
    input  logic [4:0]  vb_ofs_i,
    input  logic        vb_adv_i,
    input  logic        vb_dly_odd_i,
    input  logic        vb_dly_even_i,
    input  logic [4:0]  ve_ofs_i,
    input  logic        ve_adv_i,
    input  logic        ve_dly_odd_i,
    input  logic        ve_dly_even_i,
    input  logic [4:0]  ft_ofs_i,
    input  logic        ft_adv_i,
    input  logic        ft_dly_odd_i,
    input  logic        ft_dly_even_i,
    output logic        hs_o,
    output logic        vs_o,
    output logic        fld_o,
    output logic        v_flag_o,
    output logic        f_flag_o,
    output logic [10:0] pix_cnt_o,
    output logic [9:0]  line_cnt_o
);

    localparam int PIX_W     = HPOS_W;
    localparam int LINE_W    = $clog2(LINES_625 + 1);
    localparam int N_EDGE    = 3;
    localparam int N_FIELD   = 2;
    localparam logic [PIX_W-1:0]  PPL_A = PIX_W'(PPL_525);
    localparam logic [PIX_W-1:0]  PPL_B = PIX_W'(PPL_625);
    localparam logic [LINE_W-1:0] LPF_A = LINE_W'(LINES_525);
    localparam logic [LINE_W-1:0] LPF_B = LINE_W'(LINES_625);

    typedef struct packed {
        logic hs;
        logic vs_pin;
        logic fld_pin;
        logic v;
        logic f;
        logic vs;
    } tim_st_t;

    tim_cfg_t          cfg_in, cfg;
    logic [PIX_W-1:0]  ppl, pix_q, vs_pix;
    logic [LINE_W-1:0] lpf, line_q, ref_odd, ref_even;
    logic              frame_end;
    vedge_t            ecfg  [N_EDGE];
    logic [LINE_W-1:0] eline [N_EDGE][N_FIELD];
    tim_st_t           st_d, st_q;
    logic              in_win, vb_hit, ve_hit, ft_odd, ft_even;

    always_comb begin
        cfg_in.std625   = std_625_i;
        cfg_in.hs_beg   = hs_begin_i;
        cfg_in.hs_end   = hs_end_i;
        cfg_in.hs_inv   = hs_inv_i;
        cfg_in.vs_inv   = vs_inv_i;
        cfg_in.fld_inv  = fld_inv_i;
        cfg_in.vs_mid   = vs_midline_i;
        cfg_in.vbeg     = '{ofs: vb_ofs_i, adv: vb_adv_i, dly_odd: vb_dly_odd_i, dly_even: vb_dly_even_i};
        cfg_in.vend     = '{ofs: ve_ofs_i, adv: ve_adv_i, dly_odd: ve_dly_odd_i, dly_even: ve_dly_even_i};
        cfg_in.ftog     = '{ofs: ft_ofs_i, adv: ft_adv_i, dly_odd: ft_dly_odd_i, dly_even: ft_dly_even_i};
    end

    sync_cfg_hold u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (frame_end),
        .cfg_i  (cfg_in),
        .cfg_o  (cfg)
    );

    assign ppl      = cfg.std625 ? PPL_B : PPL_A;
    assign lpf      = cfg.std625 ? LPF_B : LPF_A;
    assign ref_odd  = LINE_W'(1);
    assign ref_even = (lpf >> 1) + 1'b1;
    assign vs_pix   = cfg.vs_mid ? (ppl >> 1) : '0;

    sync_raster_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ppl_i       (ppl),
        .lpf_i       (lpf),
        .pix_o       (pix_q),
        .line_o      (line_q),
        .frame_end_o (frame_end)
    );

    always_comb begin
        ecfg[0] = cfg.vbeg;
        ecfg[1] = cfg.vend;
        ecfg[2] = cfg.ftog;
    end

    for (genvar k = 0; k < N_EDGE; k++) begin : g_edge
        for (genvar f = 0; f < N_FIELD; f++) begin : g_fld
            sync_edge_line #(.LINE_W(LINE_W), .OFS_W(OFS_W)) u_line (
                .lpf_i   (lpf),
                .ref_i   ((f == 1) ? ref_even : ref_odd),
                .ofs_i   (ecfg[k].ofs),
                .adv_i   (ecfg[k].adv),
                .extra_i ((f == 1) ? ecfg[k].dly_even : ecfg[k].dly_odd),
                .line_o  (eline[k][f])
            );
        end
    end

    always_comb begin
        st_d    = st_q;
        vb_hit  = (line_q == eline[0][0]) || (line_q == eline[0][1]);
        ve_hit  = (line_q == eline[1][0]) || (line_q == eline[1][1]);
        ft_odd  = (line_q == eline[2][0]);
        ft_even = (line_q == eline[2][1]);

        if (cfg.hs_beg < cfg.hs_end) begin
            in_win = (pix_q >= cfg.hs_beg) && (pix_q < cfg.hs_end);
        end else if (cfg.hs_beg > cfg.hs_end) begin
            in_win = (pix_q >= cfg.hs_beg) || (pix_q < cfg.hs_end);
        end else begin
            in_win = 1'b0;
        end
        st_d.hs = in_win ^ cfg.hs_inv;

        if (pix_q == '0) begin
            if (ve_hit) begin
                st_d.v = 1'b0;
            end else if (vb_hit) begin
                st_d.v = 1'b1;
            end
            if (ft_odd) begin
                st_d.f = 1'b0;
            end else if (ft_even) begin
                st_d.f = 1'b1;
            end
        end

        if (pix_q == vs_pix) begin
            if (ve_hit) begin
                st_d.vs = 1'b0;
            end else if (vb_hit) begin
                st_d.vs = 1'b1;
            end
        end

        st_d.vs_pin  = st_d.vs ^ cfg.vs_inv;
        st_d.fld_pin = st_d.f ^ cfg.fld_inv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hs: 1'b0, vs_pin: 1'b1, fld_pin: 1'b0, v: 1'b1, f: 1'b0, vs: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o       = st_q.hs;
    assign vs_o       = st_q.vs_pin;
    assign fld_o      = st_q.fld_pin;
    assign v_flag_o   = st_q.v;
    assign f_flag_o   = st_q.f;
    assign pix_cnt_o  = pix_q;
    assign line_cnt_o = line_q;

    // R4: the vertical flag only moves after a line-start pixel
    assert_v_line_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_q != '0) |=> $stable(st_q.v));

    // R5: the field flag only moves after a line-start pixel
    assert_f_line_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_q != '0) |=> $stable(st_q.f));

    // R6: internal VS state only moves after the selected phase pixel
    assert_vs_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_q != vs_pix) |=> $stable(st_q.vs));

    // R6: in line-start mode VS tracks V exactly
    assert_vs_tracks_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.vs_mid) |=> (st_q.vs == st_q.v));

    // R2: an empty window leaves HS at its idle level
    assert_hs_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_beg == cfg.hs_end) |=> (hs_o == $past(cfg.hs_inv)));

    // R7: held configuration changes only across a frame boundary
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_end) |=> $stable(cfg));

endmodule

// File: tb/sync_timing_gen_bench.sv
module sync_timing_gen_bench;
    import sync_gen_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PPL_A      = 20;
    localparam int PPL_B      = 24;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        std_625_i, hs_inv_i, vs_inv_i, fld_inv_i, vs_midline_i;
    logic [10:0] hs_begin_i, hs_end_i;
    logic [4:0]  vb_ofs_i, ve_ofs_i, ft_ofs_i;
    logic        vb_adv_i, vb_dly_odd_i, vb_dly_even_i;
    logic        ve_adv_i, ve_dly_odd_i, ve_dly_even_i;
    logic        ft_adv_i, ft_dly_odd_i, ft_dly_even_i;
    logic        hs_o, vs_o, fld_o, v_flag_o, f_flag_o;
    logic [10:0] pix_cnt_o;
    logic [9:0]  line_cnt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    tim_cfg_t m_cfg;
    int m_pix, m_line, m_wraps;
    bit m_v, m_f, m_vs, m_hs, m_vsp, m_fldp;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_timing_gen #(.PPL_525(PPL_A), .PPL_625(PPL_B)) u_sync_timing_gen (
        .clk(clk), .rst_n(rst_n), .std_625_i(std_625_i),
        .hs_begin_i(hs_begin_i), .hs_end_i(hs_end_i),
        .hs_inv_i(hs_inv_i), .vs_inv_i(vs_inv_i), .fld_inv_i(fld_inv_i),
        .vs_midline_i(vs_midline_i),
        .vb_ofs_i(vb_ofs_i), .vb_adv_i(vb_adv_i), .vb_dly_odd_i(vb_dly_odd_i), .vb_dly_even_i(vb_dly_even_i),
        .ve_ofs_i(ve_ofs_i), .ve_adv_i(ve_adv_i), .ve_dly_odd_i(ve_dly_odd_i), .ve_dly_even_i(ve_dly_even_i),
        .ft_ofs_i(ft_ofs_i), .ft_adv_i(ft_adv_i), .ft_dly_odd_i(ft_dly_odd_i), .ft_dly_even_i(ft_dly_even_i),
        .hs_o(hs_o), .vs_o(vs_o), .fld_o(fld_o), .v_flag_o(v_flag_o), .f_flag_o(f_flag_o),
        .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (pix %0d line %0d)", tag, act, exp, m_pix, m_line);
        end
    endtask

    function automatic tim_cfg_t inputs_now();
        tim_cfg_t c;
        c.std625  = std_625_i;
        c.hs_beg  = hs_begin_i;
        c.hs_end  = hs_end_i;
        c.hs_inv  = hs_inv_i;
        c.vs_inv  = vs_inv_i;
        c.fld_inv = fld_inv_i;
        c.vs_mid  = vs_midline_i;
        c.vbeg    = '{ofs: vb_ofs_i, adv: vb_adv_i, dly_odd: vb_dly_odd_i, dly_even: vb_dly_even_i};
        c.vend    = '{ofs: ve_ofs_i, adv: ve_adv_i, dly_odd: ve_dly_odd_i, dly_even: ve_dly_even_i};
        c.ftog    = '{ofs: ft_ofs_i, adv: ft_adv_i, dly_odd: ft_dly_odd_i, dly_even: ft_dly_even_i};
        return c;
    endfunction

    // R4: reference line, signed offset, per-field extra line, wrap into 1..L
    function automatic int edge_at(input int lpf, input bit even, input vedge_t e);
        int x;
        x = even ? (lpf / 2 + 1) : 1;
        x = e.adv ? x - int'(e.ofs) : x + int'(e.ofs);
        x = x + (even ? int'(e.dly_even) : int'(e.dly_odd));
        while (x < 1) x = x + lpf;
        while (x > lpf) x = x - lpf;
        return x;
    endfunction

    // R2: window with wrap, empty when equal
    function automatic bit in_window(input int p, input int b, input int e);
        if (b < e) return (p >= b) && (p < e);
        if (b > e) return (p >= b) || (p < e);
        return 1'b0;
    endfunction

    task automatic model_step();
        int ppl, lpf, vpix;
        bit vb, ve, fo, fe;
        ppl  = m_cfg.std625 ? PPL_B : PPL_A;
        lpf  = m_cfg.std625 ? 625 : 525;
        vpix = m_cfg.vs_mid ? ppl / 2 : 0;
        vb = (m_line == edge_at(lpf, 0, m_cfg.vbeg)) || (m_line == edge_at(lpf, 1, m_cfg.vbeg));
        ve = (m_line == edge_at(lpf, 0, m_cfg.vend)) || (m_line == edge_at(lpf, 1, m_cfg.vend));
        fo = (m_line == edge_at(lpf, 0, m_cfg.ftog));
        fe = (m_line == edge_at(lpf, 1, m_cfg.ftog));
        m_hs = in_window(m_pix, int'(m_cfg.hs_beg), int'(m_cfg.hs_end)) ^ m_cfg.hs_inv;
        if (m_pix == 0) begin
            if (ve) m_v = 1'b0; else if (vb) m_v = 1'b1;   // R9 end wins
            if (fo) m_f = 1'b0; else if (fe) m_f = 1'b1;
        end
        if (m_pix == vpix) begin
            if (ve) m_vs = 1'b0; else if (vb) m_vs = 1'b1;
        end
        m_vsp  = m_vs ^ m_cfg.vs_inv;
        m_fldp = m_f ^ m_cfg.fld_inv;
        if (m_pix == ppl - 1) begin
            m_pix = 0;
            if (m_line == lpf) begin
                m_line = 1;
                m_cfg  = inputs_now();   // R7 sampled on last pixel only
                m_wraps++;
            end else begin
                m_line++;
            end
        end else begin
            m_pix++;
        end
    endtask

    task automatic compare_all(input string scen);
        chk({"R1 pixel ", scen}, int'(pix_cnt_o), m_pix);
        chk({"R1 line ", scen}, int'(line_cnt_o), m_line);
        chk({"R2/R3 hs ", scen}, int'(hs_o), int'(m_hs));
        chk({"R6/R3 vs ", scen}, int'(vs_o), int'(m_vsp));
        chk({"R5/R3 fld ", scen}, int'(fld_o), int'(m_fldp));
        chk({"R4/R9 vflag ", scen}, int'(v_flag_o), int'(m_v));
        chk({"R5 fflag ", scen}, int'(f_flag_o), int'(m_f));
    endtask

    task automatic cycle(input string scen);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(scen);
    endtask

    task automatic run_cycles(input int n, input string scen);
        for (int i = 0; i < n; i++) cycle(scen);
    endtask

    task automatic run_frames(input int n, input string scen);
        int target;
        target = m_wraps + n;
        while (m_wraps < target) cycle(scen);
        run_cycles(40, scen);
    endtask

    task automatic set_defaults();
        std_625_i = 1'b0; hs_begin_i = 11'd0; hs_end_i = 11'd64;
        hs_inv_i = 1'b0; vs_inv_i = 1'b0; fld_inv_i = 1'b0; vs_midline_i = 1'b0;
        vb_ofs_i = 5'd5;  vb_adv_i = 1'b1; vb_dly_odd_i = 1'b0; vb_dly_even_i = 1'b0;
        ve_ofs_i = 5'd14; ve_adv_i = 1'b0; ve_dly_odd_i = 1'b0; ve_dly_even_i = 1'b0;
        ft_ofs_i = 5'd3;  ft_adv_i = 1'b1; ft_dly_odd_i = 1'b0; ft_dly_even_i = 1'b0;
    endtask

    // R8: values held during reset
    task automatic t_reset();
        set_defaults();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset pixel", int'(pix_cnt_o), 0);
        chk("R8 reset line", int'(line_cnt_o), 1);
        chk("R8 reset hs", int'(hs_o), 0);
        chk("R8 reset vs", int'(vs_o), 1);
        chk("R8 reset fld", int'(fld_o), 0);
        chk("R8 reset vflag", int'(v_flag_o), 1);
        chk("R8 reset fflag", int'(f_flag_o), 0);
        m_cfg = CFG_RESET; m_pix = 0; m_line = 1; m_wraps = 0;
        m_v = 1'b1; m_f = 1'b0; m_vs = 1'b1; m_hs = 1'b0; m_vsp = 1'b1; m_fldp = 1'b0;
        rst_n = 1'b1;
    endtask

    // R7 reset configuration, R1/R4/R5/R6 under defaults
    task automatic t_defaults();
        set_defaults();
        hs_end_i = 11'd7;
        run_frames(1, "R7 defaults");
    endtask

    // R2 wrapped window, R3 inversions, R4 delays both ways, R6 mid-line
    task automatic t_offsets();
        hs_begin_i = 11'd15; hs_end_i = 11'd4;
        hs_inv_i = 1'b1; vs_inv_i = 1'b1; fld_inv_i = 1'b1; vs_midline_i = 1'b1;
        vb_ofs_i = 5'd7;  vb_adv_i = 1'b0; vb_dly_even_i = 1'b1;
        ve_ofs_i = 5'd2;  ve_adv_i = 1'b1; ve_dly_odd_i = 1'b1;
        ft_ofs_i = 5'd31; ft_adv_i = 1'b0; ft_dly_odd_i = 1'b1;
        run_frames(2, "offsets");
    endtask

    // R1 625-line framing
    task automatic t_std625();
        std_625_i = 1'b1; vs_midline_i = 1'b0; hs_inv_i = 1'b0;
        hs_begin_i = 11'd2; hs_end_i = 11'd9;
        vb_ofs_i = 5'd31; vb_adv_i = 1'b1; ve_ofs_i = 5'd20; ve_adv_i = 1'b0;
        run_frames(2, "R1 std625");
    endtask

    // R7 change landing mid-frame is deferred to the next frame
    task automatic t_midframe();
        run_cycles(3001, "R7 before");
        std_625_i = 1'b0; hs_begin_i = 11'd3; hs_end_i = 11'd9;
        hs_inv_i = 1'b1; vs_midline_i = 1'b1; fld_inv_i = 1'b0;
        run_frames(1, "R7 midframe");
        run_cycles(5000, "R7 after");
    endtask

    // R9 coincident edges, R2 empty window
    task automatic t_coincide();
        hs_begin_i = 11'd6; hs_end_i = 11'd6; hs_inv_i = 1'b0;
        vb_ofs_i = 5'd10; vb_adv_i = 1'b0; vb_dly_odd_i = 1'b0; vb_dly_even_i = 1'b0;
        ve_ofs_i = 5'd10; ve_adv_i = 1'b0; ve_dly_odd_i = 1'b0; ve_dly_even_i = 1'b0;
        ft_ofs_i = 5'd0; ft_adv_i = 1'b0; ft_dly_odd_i = 1'b0; ft_dly_even_i = 1'b0;
        run_frames(2, "R9 coincide");
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_offsets();
        t_std625();
        t_midframe();
        t_coincide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule